// File: doc/BRIEF.md
# Bulk OUT Endpoint Receive Controller

This block runs the device side of an OUT transaction on a single bulk endpoint. It takes a decoded OUT-token strobe, then a byte stream with its end-of-packet and packet-error indications, and it chooses the handshake the device returns. The block writes payload bytes into a local byte FIFO through a speculative write pointer. A clean packet commits that pointer, so the bytes become visible to firmware. A damaged or oversized packet rewinds the pointer to the last committed position. It leaves no trace in the FIFO, and the host receives no handshake.

Firmware drains the FIFO through a one-byte-per-strobe read port. It learns about events from three sticky flags: transfer succeeded, transfer failed, and data ready. These flags share one interrupt request. The stall control bit and the FIFO occupancy decide whether a token is refused. A stalled endpoint refuses with STALL. A busy endpoint refuses with NAK, where busy means unread data is present or the commit of the previous packet is still under way.

Top module: `bulk_out_rx`

## Requirements
- R1: A token accepted while `stall_en` is 1 gives `hs_valid` with `hs_code` = 3 (STALL) one cycle after the token. The bytes of that data phase are not stored, and `rd_count` does not change.
- R2: A token that arrives while `rd_count` is nonzero, or in the cycle right after an ACK (the commit cycle), gives `hs_code` = 2 (NAK) one cycle after the token. Its data phase is discarded, and no handshake follows its end-of-packet.
- R3: An accepted packet whose end-of-packet arrives with `rx_err` = 1 gives `hs_valid` with `hs_code` = 0 (no handshake) one cycle after end-of-packet. It sets `flag_fail` and leaves `rd_count` unchanged.
- R4: An accepted packet carrying more bytes than the FIFO depth (64) overruns. It ends like R3: code 0, `flag_fail` set, and the pointer rewound so that `rd_count` is unchanged. A packet of exactly 64 bytes is accepted.
- R5: A clean accepted packet gives `hs_code` = 1 (ACK) one cycle after end-of-packet and sets `flag_ok` in the same cycle. One cycle later, `rd_count` equals the packet length.
- R6: `flag_rdy` is set in the commit cycle when the committed packet holds at least one byte. A zero-length clean packet is still acknowledged, but it does not set `flag_rdy`.
- R7: The three flags stay set until their own clear strobe (`clr_ok`, `clr_fail` or `clr_rdy`). A clear strobe affects only its own flag. `irq` is 1 exactly when any flag is set.
- R8: Each `rd_en` cycle with `rd_empty` = 0 removes one byte, and the bytes come out in arrival order. `rd_data` shows the oldest byte. `rd_en` while `rd_empty` = 1 has no effect.
- R9: `hs_valid` is a one-cycle strobe. It appears one cycle after the token for NAK and STALL, and one cycle after end-of-packet for ACK and no-handshake. An accepted token gives no strobe at token time.
- R10: Bytes of a packet still being received are not counted. `rd_count` stays at its committed value until the commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_out | input | 1 | One-cycle strobe: OUT token addressed to this endpoint |
| stall_en | input | 1 | Endpoint stall control, sampled at the token |
| rx_valid | input | 1 | Received payload byte valid |
| rx_data | input | 8 | Received payload byte |
| rx_eop | input | 1 | One-cycle end-of-packet strobe, never together with rx_valid |
| rx_err | input | 1 | Packet error indication, sampled with rx_eop |
| hs_valid | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| rd_en | input | 1 | Firmware read strobe |
| rd_data | output | 8 | Oldest committed byte |
| rd_empty | output | 1 | No committed byte available |
| rd_count | output | 7 | Number of committed unread bytes |
| clr_ok | input | 1 | Clears flag_ok |
| clr_fail | input | 1 | Clears flag_fail |
| clr_rdy | input | 1 | Clears flag_rdy |
| flag_ok | output | 1 | Sticky transfer-success flag |
| flag_fail | output | 1 | Sticky transfer-fail flag |
| flag_rdy | output | 1 | Sticky data-ready flag |
| irq | output | 1 | Interrupt request, OR of the flags |

## Verification
The assertions check the following on every cycle:
- the STALL and NAK answer to a token,
- that an ACK or a silent ending is seen together with its flag,
- flag stickiness,
- the speculative occupancy bound,
- that `rd_count` does not change during reception or on an empty read.

Other behaviour can only be shown by the bench's scenarios:
- byte order and content through the FIFO,
- rewind after error or overrun that leaves earlier data intact,
- the NAK in the commit cycle,
- the boundary between 64 and 65 byte packets,
- the absence of `flag_rdy` on an empty packet.

// File: rtl/bulk_out_pkg.sv
package bulk_out_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SKIP = 2'd2,
    ST_UPD  = 2'd3
  } rx_state_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_OK   = 0;
  localparam int unsigned FLAG_FAIL = 1;
  localparam int unsigned FLAG_RDY  = 2;

endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rewind,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] rd_count,
  output logic [PW-1:0] spec_count,
  output logic          rd_empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_spec_q, wr_spec_d;
  logic [PW-1:0] wr_cmt_q, wr_cmt_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic          pop;

  assign rd_count   = wr_cmt_q - rd_ptr_q;
  assign spec_count = wr_spec_q - rd_ptr_q;
  assign rd_empty   = (rd_count == '0);
  assign rd_data    = mem[rd_ptr_q[AW-1:0]];
  assign pop        = rd_en && !rd_empty;

  always_comb begin
    wr_spec_d = wr_spec_q;
    if (rewind) begin
      wr_spec_d = wr_cmt_q;
    end else if (wr_en) begin
      wr_spec_d = wr_spec_q + 1'b1;
    end
    wr_cmt_d = commit ? wr_spec_q : wr_cmt_q;
    rd_ptr_d = pop ? rd_ptr_q + 1'b1 : rd_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_spec_q <= '0;
      wr_cmt_q  <= '0;
      rd_ptr_q  <= '0;
    end else begin
      wr_spec_q <= wr_spec_d;
      wr_cmt_q  <= wr_cmt_d;
      rd_ptr_q  <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_spec_q[AW-1:0]] <= wr_data;
    end
  end

endmodule

// File: rtl/rx_txn_ctrl.sv
module rx_txn_ctrl
  import bulk_out_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          stall_en,
  input  logic          rx_valid,
  input  logic          rx_eop,
  input  logic          rx_err,
  input  logic [PW-1:0] fifo_count,
  input  logic [PW-1:0] fifo_spec_count,
  output logic          wr_en,
  output logic          commit,
  output logic          rewind,
  output logic          set_ok,
  output logic          set_fail,
  output logic          set_rdy,
  output logic          tok_ready,
  output logic          receiving,
  output logic          hs_valid,
  output hs_code_e      hs_code
);

  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  rx_state_e state_q, state_d;
  logic      ovf_q, ovf_d;
  logic      hs_v_d;
  hs_code_e  hs_c_d;

  assign tok_ready = (state_q == ST_IDLE) || (state_q == ST_UPD);
  assign receiving = (state_q == ST_RECV);

  always_comb begin
    state_d  = state_q;
    ovf_d    = ovf_q;
    hs_v_d   = 1'b0;
    hs_c_d   = HS_NONE;
    wr_en    = 1'b0;
    commit   = 1'b0;
    rewind   = 1'b0;
    set_ok   = 1'b0;
    set_fail = 1'b0;
    set_rdy  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tok_out) begin
          if (stall_en) begin
            hs_v_d  = 1'b1;
            hs_c_d  = HS_STALL;
            state_d = ST_SKIP;
          end else if (fifo_count != '0) begin
            hs_v_d  = 1'b1;
            hs_c_d  = HS_NAK;
            state_d = ST_SKIP;
          end else begin
            ovf_d   = 1'b0;
            state_d = ST_RECV;
          end
        end
      end
      ST_UPD: begin
        commit  = 1'b1;
        set_rdy = (fifo_spec_count != fifo_count);
        state_d = ST_IDLE;
        if (tok_out) begin
          hs_v_d  = 1'b1;
          hs_c_d  = stall_en ? HS_STALL : HS_NAK;
          state_d = ST_SKIP;
        end
      end
      ST_RECV: begin
        if (rx_eop) begin
          hs_v_d = 1'b1;
          if (rx_err || ovf_q) begin
            hs_c_d   = HS_NONE;
            rewind   = 1'b1;
            set_fail = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            hs_c_d  = HS_ACK;
            set_ok  = 1'b1;
            state_d = ST_UPD;
          end
        end else if (rx_valid) begin
          if (ovf_q) begin
            ovf_d = 1'b1;
          end else if (fifo_spec_count == FULL_CNT) begin
            ovf_d = 1'b1;
          end else begin
            wr_en = 1'b1;
          end
        end
      end
      ST_SKIP: begin
        if (rx_eop) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ovf_q    <= 1'b0;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      state_q  <= state_d;
      ovf_q    <= ovf_d;
      hs_valid <= hs_v_d;
      hs_code  <= hs_c_d;
    end
  end

endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags,
  output logic         irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d;
    always_comb begin
      flag_d = flags[i];
      if (set_vec[i]) begin
        flag_d = 1'b1;
      end else if (clr_vec[i]) begin
        flag_d = 1'b0;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else begin
        flags[i] <= flag_d;
      end
    end
  end

  assign irq = |flags;

endmodule

// File: rtl/bulk_out_rx.sv
module bulk_out_rx
  import bulk_out_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          stall_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic          rx_err,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic [PW-1:0] rd_count,
  input  logic          clr_ok,
  input  logic          clr_fail,
  input  logic          clr_rdy,
  output logic          flag_ok,
  output logic          flag_fail,
  output logic          flag_rdy,
  output logic          irq
);

  logic          wr_en, commit, rewind;
  logic          set_ok, set_fail, set_rdy;
  logic          tok_ready, receiving;
  logic [PW-1:0] spec_cnt;
  hs_code_e      hs_code_i;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_vec;

  rx_txn_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .tok_out         (tok_out),
    .stall_en        (stall_en),
    .rx_valid        (rx_valid),
    .rx_eop          (rx_eop),
    .rx_err          (rx_err),
    .fifo_count      (rd_count),
    .fifo_spec_count (spec_cnt),
    .wr_en           (wr_en),
    .commit          (commit),
    .rewind          (rewind),
    .set_ok          (set_ok),
    .set_fail        (set_fail),
    .set_rdy         (set_rdy),
    .tok_ready       (tok_ready),
    .receiving       (receiving),
    .hs_valid        (hs_valid),
    .hs_code         (hs_code_i)
  );

  assign hs_code = hs_code_i;

  rx_byte_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (rx_data),
    .commit     (commit),
    .rewind     (rewind),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_count   (rd_count),
    .spec_count (spec_cnt),
    .rd_empty   (rd_empty)
  );

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[FLAG_OK]   = set_ok;
    set_vec[FLAG_FAIL] = set_fail;
    set_vec[FLAG_RDY]  = set_rdy;
    clr_vec[FLAG_OK]   = clr_ok;
    clr_vec[FLAG_FAIL] = clr_fail;
    clr_vec[FLAG_RDY]  = clr_rdy;
  end

  rx_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flag_vec),
    .irq     (irq)
  );

  assign flag_ok   = flag_vec[FLAG_OK];
  assign flag_fail = flag_vec[FLAG_FAIL];
  assign flag_rdy  = flag_vec[FLAG_RDY];

endmodule

// File: rtl/bulk_out_rx_chk.sv
module bulk_out_rx_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok_out,
  input logic          stall_en,
  input logic          tok_ready,
  input logic          receiving,
  input logic          commit,
  input logic          hs_valid,
  input logic [1:0]    hs_code,
  input logic          rd_en,
  input logic          rd_empty,
  input logic [PW-1:0] rd_count,
  input logic [PW-1:0] spec_cnt,
  input logic          clr_ok,
  input logic          clr_fail,
  input logic          clr_rdy,
  input logic          flag_ok,
  input logic          flag_fail,
  input logic          flag_rdy
);

  assert_stall_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out && tok_ready && stall_en |=> hs_valid && hs_code == 2'd3);

  assert_nak_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out && tok_ready && !stall_en && rd_count != '0 |=> hs_valid && hs_code == 2'd2);

  assert_silent_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && hs_code == 2'd0 |-> flag_fail);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spec_cnt <= PW'(DEPTH));

  assert_ack_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && hs_code == 2'd1 |-> flag_ok);

  assert_ok_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ok && !clr_ok |=> flag_ok);

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_fail && !clr_fail |=> flag_fail);

  assert_rdy_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rdy && !clr_rdy |=> flag_rdy);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_empty && !commit |=> $stable(rd_count));

  assert_hidden_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    receiving && !rd_en |=> $stable(rd_count));

endmodule

bind bulk_out_rx bulk_out_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tok_out   (tok_out),
  .stall_en  (stall_en),
  .tok_ready (tok_ready),
  .receiving (receiving),
  .commit    (commit),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .rd_en     (rd_en),
  .rd_empty  (rd_empty),
  .rd_count  (rd_count),
  .spec_cnt  (spec_cnt),
  .clr_ok    (clr_ok),
  .clr_fail  (clr_fail),
  .clr_rdy   (clr_rdy),
  .flag_ok   (flag_ok),
  .flag_fail (flag_fail),
  .flag_rdy  (flag_rdy)
);

// File: tb/bulk_out_rx_test.sv
module bulk_out_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int HS_NONE = 0, HS_ACK = 1, HS_NAK = 2, HS_STALL = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tok_out, stall_en, rx_valid, rx_eop, rx_err;
  logic [7:0] rx_data;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       rd_empty;
  logic [6:0] rd_count;
  logic       clr_ok, clr_fail, clr_rdy;
  logic       flag_ok, flag_fail, flag_rdy, irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] model_q[$];
  bit exp_ok, exp_fail, exp_rdy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bulk_out_rx uut (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .stall_en(stall_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop), .rx_err(rx_err),
    .hs_valid(hs_valid), .hs_code(hs_code), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_count(rd_count), .clr_ok(clr_ok),
    .clr_fail(clr_fail), .clr_rdy(clr_rdy), .flag_ok(flag_ok),
    .flag_fail(flag_fail), .flag_rdy(flag_rdy), .irq(irq)
  );

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expect_code(bit stall, bit busy, bit err, int len);
    if (stall) return HS_STALL;
    if (busy) return HS_NAK;
    if (err || len > DEPTH) return HS_NONE;
    return HS_ACK;
  endfunction

  task automatic check_flags(string req);
    check(req, "flag_ok", int'(flag_ok), int'(exp_ok));
    check(req, "flag_fail", int'(flag_fail), int'(exp_fail));
    check(req, "flag_rdy", int'(flag_rdy), int'(exp_rdy));
    check("R7", "irq", int'(irq), int'(exp_ok | exp_fail | exp_rdy));
  endtask

  // One OUT transaction; starts and ends just after a falling edge.
  task automatic do_xfer(bit stall, int len, bit err, string req);
    bit busy;
    int code;
    logic [7:0] pkt[$];
    logic v1, v2;
    logic [1:0] c1, c2;
    busy = (model_q.size() != 0);
    code = expect_code(stall, busy, err, len);
    stall_en = stall;
    tok_out  = 1'b1;
    @(negedge clk);
    tok_out  = 1'b0;
    stall_en = 1'b0;
    v1 = hs_valid; c1 = hs_code;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'($urandom);
      pkt.push_back(rx_data);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    if (len > 0) check("R10", "rd_count before eop", int'(rd_count), model_q.size());
    rx_eop = 1'b1;
    rx_err = err;
    @(negedge clk);
    rx_eop = 1'b0;
    rx_err = 1'b0;
    v2 = hs_valid; c2 = hs_code;
    @(negedge clk);
    if (code == HS_STALL || code == HS_NAK) begin
      check(req, "hs_valid after token", int'(v1), 1);
      check(req, "hs_code after token", int'(c1), code);
      check("R9", "hs_valid after eop of refused", int'(v2), 0);
    end else begin
      check("R9", "hs_valid at token", int'(v1), 0);
      check(req, "hs_valid after eop", int'(v2), 1);
      check(req, "hs_code after eop", int'(c2), code);
    end
    if (code == HS_ACK) begin
      exp_ok = 1'b1;
      if (len > 0) exp_rdy = 1'b1;
      foreach (pkt[i]) model_q.push_back(pkt[i]);
    end else if (code == HS_NONE) begin
      exp_fail = 1'b1;
    end
    check(req, "rd_count after", int'(rd_count), model_q.size());
    check_flags(req);
  endtask

  task automatic fw_read(int k);
    for (int i = 0; i < k; i++) begin
      check("R8", "rd_data", int'(rd_data), int'(model_q[0]));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      void'(model_q.pop_front());
    end
    check("R8", "rd_count after reads", int'(rd_count), model_q.size());
    check("R8", "rd_empty after reads", int'(rd_empty), int'(model_q.size() == 0));
  endtask

  task automatic fw_clear(bit c_ok, bit c_fail, bit c_rdy);
    clr_ok = c_ok; clr_fail = c_fail; clr_rdy = c_rdy;
    @(negedge clk);
    clr_ok = 1'b0; clr_fail = 1'b0; clr_rdy = 1'b0;
    if (c_ok) exp_ok = 1'b0;
    if (c_fail) exp_fail = 1'b0;
    if (c_rdy) exp_rdy = 1'b0;
    check_flags("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] c;
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    tok_out = 0; stall_en = 0; rx_valid = 0; rx_eop = 0; rx_err = 0; rx_data = 0;
    rd_en = 0; clr_ok = 0; clr_fail = 0; clr_rdy = 0;
    exp_ok = 0; exp_fail = 0; exp_rdy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R9", "reset hs_valid", int'(hs_valid), 0);
    check("R8", "reset rd_empty", int'(rd_empty), 1);
    check("R8", "reset rd_count", int'(rd_count), 0);
    check_flags("R7");

    // read while empty
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8", "empty read count", int'(rd_count), 0);
    check("R8", "empty read empty", int'(rd_empty), 1);

    // clean packet, then drain
    do_xfer(0, 4, 0, "R5");
    check("R6", "flag_rdy after data", int'(flag_rdy), 1);
    fw_read(4);
    fw_clear(1, 0, 1);

    // zero-length clean packet: ACK, no data-ready
    do_xfer(0, 0, 0, "R6");
    check("R6", "flag_rdy on empty packet", int'(flag_rdy), 0);
    fw_clear(1, 0, 0);

    // stall
    do_xfer(1, 5, 0, "R1");

    // busy with unread data
    do_xfer(0, 3, 0, "R5");
    do_xfer(0, 6, 0, "R2");
    // stall has priority over busy
    do_xfer(1, 2, 0, "R1");

    // error packet behind unread data: drain first so it is accepted
    fw_read(3);
    do_xfer(0, 7, 1, "R3");
    fw_clear(0, 1, 0);
    check("R7", "fail cleared others kept ok", int'(flag_ok), 1);

    // overrun, then exact-depth packet
    do_xfer(0, DEPTH + 1, 0, "R4");
    check("R4", "rd_empty after overrun", int'(rd_empty), 1);
    do_xfer(0, DEPTH, 0, "R4");
    fw_read(DEPTH);
    fw_clear(1, 1, 1);

    // token in the commit cycle right after an ACK
    tok_out = 1'b1;
    @(negedge clk);
    tok_out = 1'b0;
    rx_eop = 1'b1;
    @(negedge clk);
    rx_eop = 1'b0;
    check("R9", "hs_valid after empty eop", int'(hs_valid), 1);
    check("R5", "ACK for empty packet", int'(hs_code), HS_ACK);
    tok_out = 1'b1;
    @(negedge clk);
    tok_out = 1'b0;
    c = hs_code;
    check("R2", "hs_valid token in commit cycle", int'(hs_valid), 1);
    check("R2", "NAK in commit cycle", int'(c), HS_NAK);
    rx_valid = 1'b1; rx_data = 8'hA5;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_eop = 1'b1;
    @(negedge clk);
    rx_eop = 1'b0;
    check("R2", "no handshake after skipped eop", int'(hs_valid), 0);
    @(negedge clk);
    check("R2", "skipped data not stored", int'(rd_count), 0);
    exp_ok = 1'b1;
    fw_clear(1, 0, 0);

    // constrained random traffic
    for (int t = 0; t < 80; t++) begin
      bit st, er;
      int len;
      st  = ($urandom_range(0, 7) == 0);
      er  = ($urandom_range(0, 6) == 0);
      len = ($urandom_range(0, 5) == 0) ? $urandom_range(58, 70) : $urandom_range(0, 16);
      do_xfer(st, len, er, "R5");
      if ($urandom_range(0, 2) != 0) fw_read($urandom_range(0, model_q.size()));
      fw_clear(1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule